// File: doc/BRIEF.md
# Burst-of-Two Lane-Masked SRAM

This block is a synchronous single-port memory. Every command names a burst address. One accepted command takes two data beats on two cycles in a row, with one beat per rising clock edge standing in for a double-rate transfer. Beat 1 uses the word whose lowest address bit is 0, and beat 2 uses the word whose lowest address bit is 1. On a write, every beat has its own lane mask. A mask bit at 1 blocks storage of its lane, so the old contents of that lane stay in place. Lanes are 9 bits wide by default. With 4-bit lanes the same block serves a byte-wide array with nybble masking.

A read moves the two words through a sampling stage and then an output register. The output register loads only in cycles where `out_strobe` is high. Tying `out_strobe` high makes the output follow the main clock every cycle, like a conventional pipelined-read memory. Pulling it low freezes the output. Any beat that passes the stage while the output is frozen is dropped.

The command side uses valid/ready. `cmd_ready` is high when no burst is in progress and low during the second beat of a burst. The master must therefore hold a command until the ready cycle, and a burst can never be cut short. The read return is valid-only and has no back-pressure. A consumer that cannot take data gates `out_strobe` instead.

Top module: `burst_sram`

## Requirements
- R1: `cmd_ready` is 1 when no burst is in progress. In the cycle after a command is accepted (`cmd_valid` and `cmd_ready` both 1 at a rising edge), `cmd_ready` is 0, and it returns to 1 the cycle after that.
- R2: A write accepted at edge T stores beat 1 from `wr_data`/`wr_mask` sampled at T into word {addr,0}. It stores beat 2 from `wr_data`/`wr_mask` sampled at edge T+1 into word {addr,1}.
- R3: Mask bit k set to 1 leaves bits [k*LANE_W +: LANE_W] of the addressed word unchanged, and mask bit k set to 0 writes them. With 9-bit lanes, bit 0 covers data bits 0–8 and bit 1 covers bits 9–17.
- R4: The two beats of one burst take independent mask patterns, and any combination is legal.
- R5: With `out_strobe` high, a read accepted at edge T shows word {addr,0} on `rd_data` with `rd_valid`=1 after edge T+1. It shows word {addr,1} after edge T+2, and `rd_valid`=0 after edge T+3 unless another read follows. Write bursts never raise `rd_valid`.
- R6: A read accepted on the first ready cycle after a write to the same burst address returns the mask-merged result of that write.
- R7: While `out_strobe` is 0 at an edge, `rd_data` and `rd_valid` keep their values across that edge. Any beat that passes the sampling stage during that time is lost.
- R8: During a read burst, `wr_data` and `wr_mask` have no effect on the array.
- R9: After reset, `cmd_ready`=1, `rd_valid`=0 and `rd_data`=0.
- R10: With LANE_W=4, masks apply to 4-bit nybbles under the same rule as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | BASE_W | Burst address |
| wr_data | input | LANES*LANE_W | Write beat data |
| wr_mask | input | LANES | Per-lane inhibit, 1 = keep old lane |
| out_strobe | input | 1 | Output register load enable; tie high for main-clock timing |
| rd_valid | output | 1 | `rd_data` holds a read beat |
| rd_data | output | LANES*LANE_W | Read beat data |

## Verification
The bench builds two copies side by side and drives both from the same command stream. One copy uses the default 9-bit lanes, and the other sets LANE_W=4 so that its masks act on nybbles of a byte-wide word. This makes the lane boundary at bit 9 and the boundary at bit 4 visible under identical mask patterns. Both copies use BASE_W=5, so the whole 64-word array is filled first and every later read compares against a shadow that is fully known.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_BEAT2 = 1'b1
  } burst_phase_e;
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
#(
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BASE_W-1:0] cmd_addr,
  output logic              cmd_ready,
  output logic [BASE_W:0]   word_addr,
  output logic              beat_we,
  output logic              beat_re
);
  burst_phase_e      phase;
  logic [BASE_W-1:0] base_q;
  logic              write_q;
  logic              accept;

  assign cmd_ready = (phase == PH_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    if (phase == PH_IDLE) begin
      word_addr = {cmd_addr, 1'b0};
      beat_we   = accept && cmd_write;
      beat_re   = accept && !cmd_write;
    end else begin
      word_addr = {base_q, 1'b1};
      beat_we   = write_q;
      beat_re   = !write_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      base_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      phase   <= PH_BEAT2;
      base_q  <= cmd_addr;
      write_q <= cmd_write;
    end else begin
      phase   <= PH_IDLE;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int WORD_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [WORD_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wmask,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << WORD_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wmask[g]) store[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[addr];
  end
endmodule

// File: rtl/bsram_outreg.sv
module bsram_outreg #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] sample_data,
  input  logic              strobe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              st_valid;
  logic [DATA_W-1:0] st_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_data  <= '0;
    end else begin
      st_valid <= sample;
      if (sample) st_data <= sample_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (strobe) begin
      rd_valid <= st_valid;
      rd_data  <= st_data;
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int BASE_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_write,
  input  logic [BASE_W-1:0]       cmd_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES-1:0]        wr_mask,
  input  logic                    out_strobe,
  output logic                    rd_valid,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int WORD_W = BASE_W + 1;

  logic [WORD_W-1:0] word_addr;
  logic              beat_we;
  logic              beat_re;
  logic [DATA_W-1:0] arr_rdata;

  bsram_seq #(.BASE_W(BASE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .word_addr(word_addr),
    .beat_we(beat_we), .beat_re(beat_re)
  );

  bsram_array #(.WORD_W(WORD_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(beat_we), .addr(word_addr), .wdata(wr_data),
    .wmask(wr_mask), .rdata(arr_rdata)
  );

  bsram_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .sample(beat_re), .sample_data(arr_rdata),
    .strobe(out_strobe), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
  parameter int BASE_W = 5,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [BASE_W-1:0] cmd_addr,
  input logic              out_strobe,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [BASE_W:0]   word_addr
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) acc |=> !cmd_ready); // R1
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n) !cmd_ready |=> cmd_ready); // R1
  AST_BEAT1_ADDR: assert property (@(posedge clk) disable iff (!rst_n) acc |-> word_addr == {cmd_addr, 1'b0}); // R2
  AST_BEAT2_ADDR: assert property (@(posedge clk) disable iff (!rst_n) !cmd_ready |-> word_addr == {$past(cmd_addr), 1'b1}); // R2
  AST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n) out_strobe && $past(acc && !cmd_write) |=> rd_valid); // R5
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) out_strobe && $past(acc && cmd_write) |=> !rd_valid); // R5
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !out_strobe |=> $stable(rd_data) && $stable(rd_valid)); // R7
endmodule

bind burst_sram bsram_chk #(.BASE_W(BASE_W), .DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_addr(cmd_addr), .out_strobe(out_strobe),
  .rd_valid(rd_valid), .rd_data(rd_data), .word_addr(word_addr)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [4:0]  cmd_addr = '0;
  logic [17:0] wr_data = '0;
  logic [1:0]  wr_mask = '0;
  logic        out_strobe = 1'b1;
  logic        cmd_ready, cmd_ready_n, rd_valid, rd_valid_n;
  logic [17:0] rd_data;
  logic [7:0]  rd_data_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [17:0] sh9 [64];
  logic [7:0]  sh4 [64];

  always #2ns clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .out_strobe(out_strobe), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  burst_sram #(.BASE_W(5), .LANES(2), .LANE_W(4)) uut_nyb (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready_n),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .wr_data(wr_data[7:0]),
    .wr_mask(wr_mask), .out_strobe(out_strobe), .rd_valid(rd_valid_n), .rd_data(rd_data_n)
  );

  // vector: {base, beat1 data, beat1 mask, beat2 data, beat2 mask}
  localparam int NV = 8;
  localparam logic [44:0] VEC [NV] = '{
    {5'd3,  18'h2A5A5, 2'b00, 18'h15A5A, 2'b11},
    {5'd3,  18'h3FFFF, 2'b01, 18'h00000, 2'b10},
    {5'd7,  18'h12345, 2'b10, 18'h3C3C3, 2'b01},
    {5'd0,  18'h00000, 2'b11, 18'h3FFFF, 2'b00},
    {5'd31, 18'h1FE01, 2'b00, 18'h201FE, 2'b00},
    {5'd31, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11},
    {5'd16, 18'h0F0F0, 2'b01, 18'h30F0F, 2'b01},
    {5'd16, 18'h2AAAA, 2'b10, 18'h15555, 2'b10}
  };

  function automatic logic [17:0] mrg9(logic [17:0] o, logic [17:0] n, logic [1:0] m);
    logic [17:0] r = o;
    for (int k = 0; k < 2; k++) if (!m[k]) r[k*9 +: 9] = n[k*9 +: 9];
    return r;
  endfunction

  function automatic logic [7:0] mrg4(logic [7:0] o, logic [7:0] n, logic [1:0] m);
    logic [7:0] r = o;
    for (int k = 0; k < 2; k++) if (!m[k]) r[k*4 +: 4] = n[k*4 +: 4];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1 R2 R3 R4 R10: two-beat write, shadow updated with the lane rule
  task automatic bwrite(logic [4:0] b, logic [17:0] d1, logic [1:0] m1,
                        logic [17:0] d2, logic [1:0] m2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = b; wr_data = d1; wr_mask = m1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = d2; wr_mask = m2;
    chk("R1 ready low in beat 2", {31'd0, cmd_ready}, 32'd0);
    @(posedge clk);
    sh9[{b, 1'b0}] = mrg9(sh9[{b, 1'b0}], d1, m1);
    sh9[{b, 1'b1}] = mrg9(sh9[{b, 1'b1}], d2, m2);
    sh4[{b, 1'b0}] = mrg4(sh4[{b, 1'b0}], d1[7:0], m1);
    sh4[{b, 1'b1}] = mrg4(sh4[{b, 1'b1}], d2[7:0], m2);
  endtask

  // R5: beats after T+1 and T+2; wr_data/wr_mask carry junk (R8)
  task automatic bread(logic [4:0] b, string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = b; wr_data = 18'h3DEAD; wr_mask = 2'b00;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; wr_data = 18'h1BEEF;
    @(posedge clk);
    @(negedge clk);
    chk({req, " beat1 valid"}, {31'd0, rd_valid}, 32'd1);
    chk({req, " beat1"}, {14'd0, rd_data}, {14'd0, sh9[{b, 1'b0}]});
    chk({req, " R10 beat1 nybble"}, {24'd0, rd_data_n}, {24'd0, sh4[{b, 1'b0}]});
    @(posedge clk);
    @(negedge clk);
    chk({req, " beat2"}, {14'd0, rd_data}, {14'd0, sh9[{b, 1'b1}]});
    chk({req, " R10 beat2 nybble"}, {24'd0, rd_data_n}, {24'd0, sh4[{b, 1'b1}]});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 ready after reset", {31'd0, cmd_ready}, 32'd1);
    chk("R9 rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    chk("R9 rd_data after reset", {14'd0, rd_data}, 32'd0);
    rst_n = 1'b1;

    for (int b = 0; b < 32; b++)
      bwrite(5'(b), 18'(b * 4099 + 7), 2'b00, 18'(b * 2053 + 91), 2'b00);

    // table walk: write then back-to-back read of the same burst (R2 R3 R4 R6)
    for (int i = 0; i < NV; i++) begin
      bwrite(VEC[i][44:40], VEC[i][39:22], VEC[i][21:20], VEC[i][19:2], VEC[i][1:0]);
      bread(VEC[i][44:40], "R6 R3 R4 merged readback");
    end

    // R5: after a read completes rd_valid drops
    @(negedge clk);
    chk("R5 valid drops", {31'd0, rd_valid}, 32'd0);

    // R8: a read carrying junk wr_data leaves the array unchanged
    bread(5'd9, "R8 first read");
    bread(5'd9, "R8 second read");

    // R7: strobe low freezes output, beat 2 lost
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 5'd7;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7 beat1 before freeze", {14'd0, rd_data}, {14'd0, sh9[14]});
    out_strobe = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R7 held data", {14'd0, rd_data}, {14'd0, sh9[14]});
    chk("R7 held valid", {31'd0, rd_valid}, 32'd1);
    out_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 beat2 dropped", {31'd0, rd_valid}, 32'd0);

    // R1: ready back high after the last burst
    chk("R1 ready idle", {31'd0, cmd_ready}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule